// File: doc/BRIEF.md
# Single-Wire Bus Slave Time-Slot Interface

This block is the bit-level physical layer of a slave on a single-wire, open-drain bus that idles high. It runs from a system clock and converts time into microseconds with a prescaler. The block watches a bus input that is synchronised and filtered. It controls one pull-low output, which the pad turns into an open-drain driver. Every event on the bus is timed from the falling edge that the master drives.

When the master holds the line low for a long time, the block reads this as a bus reset. It pulses a strobe to the upper layer and then answers with a presence pulse. A short low is a write of 1 and a long low is a write of 0. The block reports each received bit with a one-cycle strobe.

If the upper layer has armed a transmit bit when a slot begins, the slot becomes a read slot. The block takes the bit and acknowledges it. To send a 0, it holds the line low past the data-valid point. To send a 1, it leaves the line alone. Bits cross the bus least significant first. Putting bits into that order is the job of the layer above.

Top module: `owire_slot_phy`

## Requirements
- R1: After reset, `bus_pull` is 0 and none of the strobes `rst_seen`, `rx_valid` or `tx_take` is active.
- R2: A filtered low of at least 480 µs gives exactly one `rst_seen` pulse when the line rises. A low of 400 µs gives none.
- R3: After a reset ends, `bus_pull` goes to 1 between 15 and 60 µs after the line rises (nominally 30 µs). It stays at 1 for between 60 and 240 µs (nominally 120 µs), and no other presence pulse follows a low that is shorter than a reset.
- R4: In a slot that is not armed, a master low of 1 to 15 µs gives one `rx_valid` pulse with `rx_bit` = 1. The line is sampled 30 µs after the falling edge.
- R5: In a slot that is not armed, a master low of 60 to 120 µs gives one `rx_valid` pulse with `rx_bit` = 0.
- R6: If `tx_arm` = 1 and `tx_bit` = 0 at a falling edge, the block gives one `tx_take` pulse. It also drives `bus_pull` = 1 from the edge until 45 µs after it, so the pull is 1 at 20 µs and 0 at 50 µs. The slot produces no `rx_valid`.
- R7: If `tx_arm` = 1 and `tx_bit` = 1 at a falling edge, the block gives one `tx_take` pulse. It leaves `bus_pull` at 0 for the whole slot and produces no `rx_valid`.
- R8: A low that lasts less than one microsecond tick gives no strobe and no pull.
- R9: Each slot yields at most one `rx_valid`. A new slot is accepted only after the line has been high again, so slots of 67 µs with 2 µs recovery deliver every bit in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_in | input | 1 | Raw level of the bus line |
| bus_pull | output | 1 | 1 = pull the bus line low |
| tx_arm | input | 1 | Treat the next slot as a read slot |
| tx_bit | input | 1 | Bit to send in an armed slot |
| tx_take | output | 1 | One-cycle pulse: the armed bit was taken at slot start |
| rst_seen | output | 1 | One-cycle pulse: a bus reset ended |
| rx_valid | output | 1 | One-cycle pulse: a received bit is on `rx_bit` |
| rx_bit | output | 1 | Received bit value |

## Verification
Write lows of 2, 15, 60 and 120 µs are placed on either side of the 30 µs sample point, so a sample point that moves shows up as a wrong bit. Armed read slots of 0 and 1 use the same short master low, which means the only difference between them is the drive seen at 20 µs and its release before 50 µs. A 500 µs low and a 400 µs low fall on either side of the reset threshold, and the presence delay and width are measured in microseconds. A two-cycle glitch and a burst of slots spaced closely together test the filter and the return to idle between slots.

// File: rtl/owire_pkg.sv
`timescale 1ns/1ps
package owire_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RSTLOW,
    ST_PDWAIT,
    ST_PDDRIVE
  } slot_st_e;
endpackage

// File: rtl/owire_line_filter.sv
`timescale 1ns/1ps
module owire_line_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_lvl,
  output logic line_fell,
  output logic line_rose
);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic          s1_q, s2_q, lvl_q, lvl_d;
  logic [FW-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (s2_q != lvl_q) begin
      if (cnt_q == FW'(FILT_CYC - 1)) lvl_d = s2_q;
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q  <= line_raw;
      s2_q  <= s1_q;
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign line_lvl  = lvl_q;
  assign line_fell = lvl_q & ~lvl_d;
  assign line_rose = ~lvl_q & lvl_d;

  // R8
  filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(s2_q) == lvl_q));
endmodule

// File: rtl/owire_us_tick.sv
`timescale 1ns/1ps
module owire_us_tick #(
  parameter int TICKS_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = $clog2(TICKS_PER_US + 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == PW'(TICKS_PER_US - 1)) & ~clr;

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/owire_slot_fsm.sv
`timescale 1ns/1ps
module owire_slot_fsm
  import owire_pkg::*;
#(
  parameter int RESET_US    = 480,
  parameter int SAMPLE_US   = 30,
  parameter int RELEASE_US  = 45,
  parameter int PD_DELAY_US = 30,
  parameter int PD_LEN_US   = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_lvl,
  input  logic line_fell,
  input  logic line_rose,
  input  logic us_tick,
  input  logic tx_arm,
  input  logic tx_bit,
  output logic tick_clr,
  output logic pull,
  output logic tx_take,
  output logic rst_seen,
  output logic rx_valid,
  output logic rx_bit
);
  localparam int CW = $clog2(RESET_US + 1) + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;

  slot_st_e      st_q, st_d;
  logic [CW-1:0] us_q, us_d, us_inc;
  logic          rd_q, rd_d, bit_q, bit_d, smp_q, smp_d;
  logic          rd_drive;

  assign us_inc   = (us_tick && us_q != CNT_MAX) ? us_q + 1'b1 : us_q;
  assign rd_drive = (st_q == ST_SLOT) && rd_q && !bit_q && (us_q < CW'(RELEASE_US));
  assign pull     = rd_drive || (st_q == ST_PDDRIVE);

  always_comb begin
    st_d     = st_q;
    us_d     = us_q;
    rd_d     = rd_q;
    bit_d    = bit_q;
    smp_d    = smp_q;
    tick_clr = 1'b0;
    tx_take  = 1'b0;
    rst_seen = 1'b0;
    rx_valid = 1'b0;
    rx_bit   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (line_fell) begin
          st_d     = ST_SLOT;
          us_d     = '0;
          tick_clr = 1'b1;
          rd_d     = tx_arm;
          bit_d    = tx_bit;
          tx_take  = tx_arm;
          smp_d    = 1'b0;
        end
      end
      ST_SLOT: begin
        us_d = us_inc;
        if (!smp_q && us_q == CW'(SAMPLE_US)) begin
          smp_d    = 1'b1;
          rx_valid = !rd_q;
          rx_bit   = line_lvl;
        end
        if (!line_lvl && us_q >= CW'(RESET_US)) st_d = ST_RSTLOW;
        else if (line_lvl && smp_q && !rd_drive) st_d = ST_IDLE;
      end
      ST_RSTLOW: begin
        if (line_rose) begin
          st_d     = ST_PDWAIT;
          rst_seen = 1'b1;
          us_d     = '0;
          tick_clr = 1'b1;
        end
      end
      ST_PDWAIT: begin
        us_d = us_inc;
        if (us_q == CW'(PD_DELAY_US)) begin
          st_d     = ST_PDDRIVE;
          us_d     = '0;
          tick_clr = 1'b1;
        end
      end
      ST_PDDRIVE: begin
        us_d = us_inc;
        if (us_q == CW'(PD_LEN_US)) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      us_q  <= '0;
      rd_q  <= 1'b0;
      bit_q <= 1'b0;
      smp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      us_q  <= us_d;
      rd_q  <= rd_d;
      bit_q <= bit_d;
      smp_q <= smp_d;
    end
  end

  // R2
  rst_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen |=> !rst_seen);
  // R9
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R3
  pd_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PDDRIVE) |-> (us_q <= CW'(PD_LEN_US)));
  // R6
  rd_release_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pull) && st_q == ST_SLOT) |-> (us_q >= CW'(RELEASE_US)));
endmodule

// File: rtl/owire_slot_phy.sv
`timescale 1ns/1ps
module owire_slot_phy #(
  parameter int TICKS_PER_US = 200,
  parameter int RESET_US     = 480,
  parameter int SAMPLE_US    = 30,
  parameter int RELEASE_US   = 45,
  parameter int PD_DELAY_US  = 30,
  parameter int PD_LEN_US    = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic bus_pull,
  input  logic tx_arm,
  input  logic tx_bit,
  output logic tx_take,
  output logic rst_seen,
  output logic rx_valid,
  output logic rx_bit
);
  logic rs1_q, rs2_q;
  logic lvl, fell, rose, tick, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  owire_line_filter #(.FILT_CYC(TICKS_PER_US)) u_filt (
    .clk(clk), .rst_n(rs2_q), .line_raw(bus_in),
    .line_lvl(lvl), .line_fell(fell), .line_rose(rose)
  );

  owire_us_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
    .clk(clk), .rst_n(rs2_q), .clr(clr), .tick(tick)
  );

  owire_slot_fsm #(
    .RESET_US(RESET_US), .SAMPLE_US(SAMPLE_US), .RELEASE_US(RELEASE_US),
    .PD_DELAY_US(PD_DELAY_US), .PD_LEN_US(PD_LEN_US)
  ) u_fsm (
    .clk(clk), .rst_n(rs2_q), .line_lvl(lvl), .line_fell(fell),
    .line_rose(rose), .us_tick(tick), .tx_arm(tx_arm), .tx_bit(tx_bit),
    .tick_clr(clr), .pull(bus_pull), .tx_take(tx_take),
    .rst_seen(rst_seen), .rx_valid(rx_valid), .rx_bit(rx_bit)
  );

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rs2_q)
    $rose(rs2_q) |-> !bus_pull);
endmodule

// File: tb/owire_slot_phy_test.sv
`timescale 1ns/1ps
module owire_slot_phy_test;
  localparam int TK = 4;

  logic clk = 1'b0;
  logic rst_n, m_low, tx_arm, tx_bit;
  logic bus_pull, tx_take, rst_seen, rx_valid, rx_bit;
  wire  bus_line = !(m_low | bus_pull);

  int n_chk = 0, n_fail = 0;
  int rx_cnt = 0, rst_cnt = 0, take_cnt = 0, pull_cyc = 0;
  logic rx_last = 1'b0;
  logic [7:0] rx_shift = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  owire_slot_phy #(.TICKS_PER_US(TK)) uut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_line), .bus_pull(bus_pull),
    .tx_arm(tx_arm), .tx_bit(tx_bit), .tx_take(tx_take),
    .rst_seen(rst_seen), .rx_valid(rx_valid), .rx_bit(rx_bit)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_bit; rx_shift = {rx_bit, rx_shift[7:1]}; end
    if (rst_seen) rst_cnt++;
    if (tx_take) take_cnt++;
    if (bus_pull) pull_cyc++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic us(input int n);
    step(n * TK);
  endtask

  task automatic slot(input int low, input int total, output logic p20);
    p20 = 1'b0;
    m_low = 1'b1;
    for (int t = 0; t < total; t++) begin
      if (t == low) m_low = 1'b0;
      if (t == 20) p20 = bus_pull;
      us(1);
    end
    m_low = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // {arm, bit, low_us[7:0], exp_rx, exp_bit, exp_pull20}
  localparam logic [12:0] VEC [7] = '{
    {1'b0, 1'b0, 8'd2,   1'b1, 1'b1, 1'b0},  // R4
    {1'b0, 1'b0, 8'd15,  1'b1, 1'b1, 1'b0},  // R4
    {1'b0, 1'b0, 8'd60,  1'b1, 1'b0, 1'b1},  // R5 (master low at 20)
    {1'b0, 1'b0, 8'd120, 1'b1, 1'b0, 1'b1},  // R5
    {1'b1, 1'b0, 8'd2,   1'b0, 1'b0, 1'b1},  // R6
    {1'b1, 1'b1, 8'd2,   1'b0, 1'b0, 1'b0},  // R7
    {1'b0, 1'b0, 8'd5,   1'b1, 1'b1, 1'b0}   // R4
  };

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic p20;
    int rx0, tk0, rs0, pc0, c;
    rst_n = 1'b0; m_low = 1'b0; tx_arm = 1'b0; tx_bit = 1'b0;
    step(5);
    rst_n = 1'b1;
    step(5);
    // R1
    chk(!bus_pull, "R1 pull after reset", bus_pull, 0);
    chk(rx_cnt == 0 && rst_cnt == 0 && take_cnt == 0, "R1 strobes after reset",
        rx_cnt + rst_cnt + take_cnt, 0);
    us(5);

    foreach (VEC[i]) begin
      rx0 = rx_cnt; tk0 = take_cnt;
      tx_arm = VEC[i][12]; tx_bit = VEC[i][11];
      slot(int'(VEC[i][10:3]), 130, p20);
      tx_arm = 1'b0;
      us(3);
      chk(rx_cnt - rx0 == int'(VEC[i][2]), $sformatf("R4/R5/R6/R7 vec%0d rx count", i),
          rx_cnt - rx0, VEC[i][2]);
      if (VEC[i][2])
        chk(rx_last == VEC[i][1], $sformatf("R4/R5 vec%0d rx bit", i), rx_last, VEC[i][1]);
      chk(take_cnt - tk0 == int'(VEC[i][12]), $sformatf("R6/R7 vec%0d take", i),
          take_cnt - tk0, VEC[i][12]);
      if (VEC[i][12])
        chk((VEC[i][0] ? 1'b1 : 1'b0) == p20 && !bus_pull,
            $sformatf("R6/R7 vec%0d pull at 20us", i), p20, VEC[i][0]);
    end

    // R6 release before 50 us
    pc0 = pull_cyc;
    tx_arm = 1'b1; tx_bit = 1'b0;
    m_low = 1'b1; us(2); m_low = 1'b0; tx_arm = 1'b0;
    us(48);
    chk(!bus_pull, "R6 released by 50us", bus_pull, 0);
    c = (pull_cyc - pc0) / TK;
    chk(c >= 43 && c <= 48, "R6 drive length us", c, 45);
    us(20);

    // R2 R3 reset and presence
    rs0 = rst_cnt;
    m_low = 1'b1; us(500); m_low = 1'b0;
    c = 0;
    while (!bus_pull && c < 400 * TK) begin step(1); c++; end
    chk(rst_cnt - rs0 == 1, "R2 reset strobe after 500us low", rst_cnt - rs0, 1);
    chk(c / TK >= 15 && c / TK <= 60, "R3 presence delay us", c / TK, 30);
    c = 0;
    while (bus_pull && c < 400 * TK) begin step(1); c++; end
    chk(c / TK >= 60 && c / TK <= 240, "R3 presence width us", c / TK, 120);
    us(20);

    // R2 R3 shorter low is not a reset
    rs0 = rst_cnt; pc0 = pull_cyc;
    m_low = 1'b1; us(400); m_low = 1'b0;
    us(300);
    chk(rst_cnt == rs0, "R2 no reset for 400us low", rst_cnt - rs0, 0);
    chk(pull_cyc == pc0, "R3 no presence for 400us low", pull_cyc - pc0, 0);

    // R8 glitch
    rx0 = rx_cnt; pc0 = pull_cyc;
    m_low = 1'b1; step(2); m_low = 1'b0;
    us(80);
    chk(rx_cnt == rx0, "R8 glitch gives no bit", rx_cnt - rx0, 0);
    chk(pull_cyc == pc0, "R8 glitch gives no pull", pull_cyc - pc0, 0);

    // R9 back-to-back slots, bits 1,0,1,1 first to last
    rx0 = rx_cnt;
    slot(5, 67, p20);
    slot(65, 67, p20);
    slot(5, 67, p20);
    slot(5, 67, p20);
    us(5);
    chk(rx_cnt - rx0 == 4, "R9 burst bit count", rx_cnt - rx0, 4);
    chk(rx_shift[7:4] == 4'b1101, "R9 burst bit order", rx_shift[7:4], 4'b1101);

    done = 1'b1;
    finish_run();
  end
endmodule